// File: doc/BRIEF.md
# Sparse GPIO Output Port with Atomic Bit Set and Clear

This block holds the output-data state of one 16-pin general-purpose output port and drives it to the pad logic. Software reaches it through a simple register bus with an address, a write enable, write data and combinational read data. There are two registers. The first is a plain output-data register that can be read and written as a whole. The second is a write-only set/clear register. It lets software raise or lower individual pins in a single bus write, so no read-modify-write sequence is needed and no race with other writers can occur.

Only a sparse subset of the pins is built: pins 15 down to 13 and pins 6 down to 0. A parameter mask names the implemented pins. The flops for the missing pins are held at zero, and request bits aimed at those pins are dropped.

Top module: `gpio_out_port`

## Requirements
- R1: While reset is asserted, and right after it is released, `pinOut` is all zeros and the output-data register reads back as zero.
- R2: A write to the set/clear register at offset 0x818 drives output bit y to 1 for every implemented pin y whose write-data bit y (lower half) is 1.
- R3: A write to the set/clear register drives output bit y to 0 for every implemented pin y whose write-data bit 16+y (upper half) is 1, provided bit y of the same write is 0.
- R4: When one set/clear write has both bit y and bit 16+y at 1, output bit y becomes 1, because the set request has priority.
- R5: During a set/clear write, every output bit whose set bit and clear bit are both 0 keeps its previous value.
- R6: Write-data bits 12:7 and 28:23 of a set/clear write change no state. Output bits 12:7 are always 0.
- R7: A read of the set/clear register (offset 0x818) returns 0 in all 32 bits.
- R8: The output-data register at offset 0x814 takes write-data bits 15:0, masked to the implemented pins. It reads back in bits 15:0, with zeros for the missing pins and in bits 31:16.
- R9: A write takes effect on the rising clock edge at which the write enable is sampled high, so `pinOut` shows the new value right after that edge. Cycles with the write enable low, and writes to any other offset, leave `pinOut` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12 | Register byte offset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for `busAddr` |
| pinOut | output | 16 | Output data driven to the pads |

## Verification
The bench uses the default parameters: a 16-pin port with implemented-pin mask 0xE07F, data-register offset 0x814 and set/clear offset 0x818. Because the real sparse mask is in place, random write data lands on reserved positions and on missing pins, and the bench can compare each result against a masked model. Full 32-bit random set/clear words also produce frequent same-pin set-and-clear collisions, which exercise the set-over-clear priority. The 12-bit address lets the stimulus include writes to unrelated offsets, which show that such writes are ignored.

// File: rtl/gpio_out_pkg.sv
package gpio_out_pkg;

  // Strobes from the address decoder to the output-data datapath
  typedef struct packed {
    logic odrWrite;   // whole-register write of the output data
    logic bsrWrite;   // atomic set/clear write
    logic odrRead;    // output-data register selected for reading
  } ctrl_strobes_t;

endpackage

// File: rtl/gpio_out_ctrl.sv
module gpio_out_ctrl
  import gpio_out_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] ODR_OFFSET = 12'h814,
  parameter logic [ADDR_W-1:0] BSR_OFFSET = 12'h818
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctrl_strobes_t     strobes
);

  logic hitOdr;
  logic hitBsr;

  always_comb begin
    hitOdr           = (busAddr == ODR_OFFSET);
    hitBsr           = (busAddr == BSR_OFFSET);
    strobes.odrWrite = busWrEn && hitOdr;
    strobes.bsrWrite = busWrEn && hitBsr;
    // the set/clear register has no read path: it always returns zero
    strobes.odrRead  = hitOdr;
  end

endmodule

// File: rtl/gpio_out_dp.sv
module gpio_out_dp
  import gpio_out_pkg::*;
#(
  parameter int unsigned PIN_COUNT = 16,
  parameter int unsigned BUS_W     = 32,
  parameter logic [PIN_COUNT-1:0] PIN_MASK = 16'hE07F
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrl_strobes_t        strobes,
  input  logic [BUS_W-1:0]     wrData,
  output logic [PIN_COUNT-1:0] odrQ
);

  localparam int unsigned CLR_LSB = PIN_COUNT;
  localparam int unsigned CLR_MSB = 2 * PIN_COUNT - 1;

  logic [PIN_COUNT-1:0] setVec;
  logic [PIN_COUNT-1:0] clrVec;
  logic [PIN_COUNT-1:0] odrNext;

  always_comb begin
    // requests on reserved positions are dropped here
    setVec = wrData[PIN_COUNT-1:0] & PIN_MASK;
    clrVec = wrData[CLR_MSB:CLR_LSB] & PIN_MASK;
    if (strobes.odrWrite) begin
      odrNext = wrData[PIN_COUNT-1:0] & PIN_MASK;
    end else if (strobes.bsrWrite) begin
      // clear first, then set: set wins on a collision
      odrNext = ((odrQ & ~clrVec) | setVec) & PIN_MASK;
    end else begin
      odrNext = odrQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      odrQ <= '0;
    end else begin
      odrQ <= odrNext;
    end
  end

endmodule

// File: rtl/gpio_out_port.sv
module gpio_out_port
  import gpio_out_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BUS_W     = 32,
  parameter int unsigned PIN_COUNT = 16,
  parameter logic [PIN_COUNT-1:0] PIN_MASK   = 16'hE07F,
  parameter logic [ADDR_W-1:0]    ODR_OFFSET = 12'h814,
  parameter logic [ADDR_W-1:0]    BSR_OFFSET = 12'h818
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [BUS_W-1:0]     busWrData,
  output logic [BUS_W-1:0]     busRdData,
  output logic [PIN_COUNT-1:0] pinOut
);

  localparam int unsigned PAD_W = BUS_W - PIN_COUNT;

  ctrl_strobes_t        strobes;
  logic [PIN_COUNT-1:0] odrQ;

  gpio_out_ctrl #(
    .ADDR_W    (ADDR_W),
    .ODR_OFFSET(ODR_OFFSET),
    .BSR_OFFSET(BSR_OFFSET)
  ) ctrl_i (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .strobes(strobes)
  );

  gpio_out_dp #(
    .PIN_COUNT(PIN_COUNT),
    .BUS_W    (BUS_W),
    .PIN_MASK (PIN_MASK)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wrData (busWrData),
    .odrQ   (odrQ)
  );

  always_comb begin
    busRdData = strobes.odrRead ? {{PAD_W{1'b0}}, odrQ} : '0;
    pinOut    = odrQ;
  end

endmodule

// File: rtl/gpio_out_port_chk.sv
module gpio_out_port_chk #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BUS_W     = 32,
  parameter int unsigned PIN_COUNT = 16,
  parameter logic [PIN_COUNT-1:0] PIN_MASK   = 16'hE07F,
  parameter logic [ADDR_W-1:0]    BSR_OFFSET = 12'h818
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWrEn,
  input logic [BUS_W-1:0]     busWrData,
  input logic [BUS_W-1:0]     busRdData,
  input logic [PIN_COUNT-1:0] pinOut
);

  localparam int unsigned CLR_LSB = PIN_COUNT;
  localparam int unsigned CLR_MSB = 2 * PIN_COUNT - 1;

  logic bsrWr;
  logic [PIN_COUNT-1:0] reqSet;
  logic [PIN_COUNT-1:0] reqClr;

  always_comb begin
    bsrWr  = busWrEn && (busAddr == BSR_OFFSET);
    reqSet = busWrData[PIN_COUNT-1:0] & PIN_MASK;
    reqClr = busWrData[CLR_MSB:CLR_LSB] & PIN_MASK & ~reqSet;
  end

  // R1: reset leaves the pins low
  a_r1_reset_clear: assert property (@(posedge clk) !rstN |=> pinOut == '0);

  // R2 and R4: requested set bits are high after the write, even on a collision
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    bsrWr |=> (pinOut & $past(reqSet)) == $past(reqSet));

  // R3: clear-only requests drop their pins
  a_r3_clear_low: assert property (@(posedge clk) disable iff (!rstN)
    bsrWr |=> (pinOut & $past(reqClr)) == '0);

  // R6: missing pins never go high
  a_r6_unimpl_low: assert property (@(posedge clk) disable iff (!rstN)
    (pinOut & ~PIN_MASK) == '0);

  // R7: set/clear register reads as zero
  a_r7_bsr_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == BSR_OFFSET) |-> busRdData == '0);

  // R9: no write, no change
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> $stable(pinOut));

endmodule

bind gpio_out_port gpio_out_port_chk #(
  .ADDR_W    (ADDR_W),
  .BUS_W     (BUS_W),
  .PIN_COUNT (PIN_COUNT),
  .PIN_MASK  (PIN_MASK),
  .BSR_OFFSET(BSR_OFFSET)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busWrData(busWrData),
  .busRdData(busRdData),
  .pinOut   (pinOut)
);

// File: tb/gpio_out_port_tb_top.sv
module gpio_out_port_tb_top;

  localparam logic [15:0] MASK    = 16'hE07F;
  localparam logic [11:0] ODR_ADR = 12'h814;
  localparam logic [11:0] BSR_ADR = 12'h818;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [15:0] pinOut;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model = '0;
  logic [31:0] rd;

  always #2 clk = ~clk;  // 250 MHz

  gpio_out_port dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pinOut(pinOut)
  );

  function automatic logic [15:0] bsrModel(logic [15:0] old, logic [31:0] d);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) begin
      if (!MASK[i])        r[i] = 1'b0;
      else if (d[i])       r[i] = 1'b1;
      else if (d[16 + i])  r[i] = 1'b0;
      else                 r[i] = old[i];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at the falling edge, sample at the next falling edge
  task automatic busWrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    if (a == ODR_ADR)      model = d[15:0] & MASK;
    else if (a == BSR_ADR) model = bsrModel(model, d);
  endtask

  task automatic busRead(logic [11:0] a, output logic [31:0] d);
    busAddr = a; busWrEn = 1'b0;
    #1;
    d = busRdData;
  endtask

  task automatic checkState(string tag);
    check(tag, {16'h0, pinOut}, {16'h0, model});
    busRead(ODR_ADR, rd);
    check(tag, rd, {16'h0, model});
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: reset state, during and after reset
    @(negedge clk); @(negedge clk);
    check("R1 pins in reset", {16'h0, pinOut}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    checkState("R1 after reset");

    // R2: set implemented pins
    busWrite(BSR_ADR, 32'h0000_A005);
    checkState("R2 set some");
    // R5: zero bits keep value
    busWrite(BSR_ADR, 32'h0000_0000);
    checkState("R5 zero write keeps");
    // R3: clear one pin
    busWrite(BSR_ADR, 32'h8000_0000);
    check("R3 clear pin15", {16'h0, pinOut}, 32'h0000_2005);
    // R4: set and clear same pins
    busWrite(BSR_ADR, 32'h0041_0041);
    check("R4 set wins", {16'h0, pinOut}, 32'h0000_2045);
    // R6: reserved positions only
    busWrite(BSR_ADR, 32'h1F80_1F80);
    check("R6 reserved ignored", {16'h0, pinOut}, 32'h0000_2045);
    // R7: set/clear register reads zero
    busRead(BSR_ADR, rd);
    check("R7 bsr read", rd, 32'h0);
    // R8: direct write with reserved and upper bits
    busWrite(ODR_ADR, 32'hFFFF_FFFF);
    check("R8 odr write", {16'h0, pinOut}, 32'h0000_E07F);
    busRead(ODR_ADR, rd);
    check("R8 odr read", rd, 32'h0000_E07F);
    // R9: other offset and idle cycles
    busWrite(12'h810, 32'hFFFF_0000);
    check("R9 other offset", {16'h0, pinOut}, 32'h0000_E07F);
    @(negedge clk); busAddr = BSR_ADR; busWrData = 32'hFFFF_0000;
    @(negedge clk);
    check("R9 idle no change", {16'h0, pinOut}, 32'h0000_E07F);
    // R3: clear everything
    busWrite(BSR_ADR, 32'hFFFF_0000);
    check("R3 clear all", {16'h0, pinOut}, 32'h0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int unsigned kind = $urandom_range(0, 9);
      logic [31:0] d = $urandom;
      if (kind < 6)       busWrite(BSR_ADR, d);
      else if (kind < 8)  busWrite(ODR_ADR, d);
      else if (kind < 9)  busWrite(12'h81C, d);
      else begin
        @(negedge clk); busAddr = ODR_ADR; busWrData = d; busWrEn = 1'b0;
        @(negedge clk);
      end
      checkState("R2 R3 R4 R5 R6 R9 random");
      busRead(BSR_ADR, rd);
      check("R7 random bsr read", rd, 32'h0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule